// File: doc/BRIEF.md
# Transmit Descriptor Sequencer with Status Writeback

This block runs one half-duplex Ethernet transmit job for a single buffer descriptor. A 32-bit descriptor word arrives with a one-cycle valid strobe. It carries an ownership flag, two alignment ("widget") bits and a byte length. The block accepts the word only when the DMA side owns it. It then waits for the medium, sends the frame while it watches the MAC's per-nibble events, retries after early collisions and finally returns the descriptor word. The returned word has ownership given back to the CPU and a status field that records everything that happened.

All timing runs on a nibble-rate enable input, `nib_tick`, and not on the system clock. The thresholds for deferral abort, late collision and frame length are therefore the same at any clock frequency. Backoff delays, serialization, CRC and the bus side of the DMA belong to other blocks. Here the frame is modelled as a count of nibble slots: a frame of `len` bytes takes `2*len` slots, and a zero length takes one slot.

Top module: `txd_status_wb`

## Requirements
- R1: A descriptor presented with bit 31 = 0 (CPU owned) is ignored. `idle` stays 1, no writeback occurs and later nibble ticks start nothing. A descriptor with bit 31 = 1 is accepted from idle, and `idle` drops to 0.
- R2: Every terminal outcome produces exactly one `wb_valid` pulse of one clock. The pulse becomes visible after the clock edge that samples the deciding `nib_tick`. In the written-back word, bit 31 = 0, bit 30 = 0 and bit 24 (Complete) = 1, and bits 17:16 and 15:0 equal the descriptor's widget and length.
- R3: A frame starts on a waiting nibble tick in which the medium is free (`crs` = 0), transmit is enabled and no halt or pause is active. It ends successfully after `2*len` further nibble ticks, or after one tick when `len` = 0.
- R4: Bit 21 (No carrier) is set on a successful frame when `crs` was low on every nibble tick of its final attempt.
- R5: Bit 26 (Deferred) is set if at least one nibble tick before the first attempt saw the medium busy.
- R6: When one waiting period holds 6071 busy nibble ticks, bits 20 (Defer error) and 26 are set and the frame is aborted on the 6071st of them. A waiting period with 6070 busy ticks still transmits.
- R7: A collision in the first 128 nibble slots of an attempt sets bit 25 (Collision). The block then returns to waiting and later sends the whole frame again.
- R8: The 16th collision on one descriptor sets bits 18 (Excessive collision) and 25 and aborts the frame. After 15 collisions the frame still completes normally.
- R9: A collision when 128 or more nibbles of the attempt have been sent sets bits 22 (Late collision) and 25 and aborts the frame without a retry.
- R10: A FIFO underflow during transmission sets bit 19 and aborts the frame. A FIFO parity error sets bit 23 and aborts the frame, and it wins over an underflow in the same tick, which then leaves bit 19 clear.
- R11: While `halt_imm` = 1 or `tx_en` = 0, waiting nibble ticks do not start a frame and set bit 28 (Halted).
- R12: While `pause_req` = 1, waiting nibble ticks do not start a frame and set bit 29 (Paused).
- R13: `sqe_err` on a transmitting nibble tick sets bit 27 (SQE error) and does not end the frame.
- R14: Accepting a new descriptor clears every status bit left over from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | One-cycle strobe presenting a descriptor |
| desc_word | input | 32 | Descriptor: owner bit 31, widget 17:16, length 15:0 |
| nib_tick | input | 1 | Nibble-rate timing enable |
| crs | input | 1 | Carrier sense / medium busy |
| col | input | 1 | Collision detected |
| fifo_unf | input | 1 | Transmit FIFO underflow |
| fifo_par | input | 1 | Transmit FIFO parity error |
| sqe_err | input | 1 | Signal quality error report |
| pause_req | input | 1 | Hold-off from a received pause frame |
| halt_imm | input | 1 | Halt-immediate control |
| tx_en | input | 1 | Transmit enable |
| idle | output | 1 | No descriptor in progress |
| wb_valid | output | 1 | One-cycle writeback strobe |
| wb_word | output | 32 | Returned descriptor word with status |

## Verification
The hardest situation to reach from the ports is the excessive-collision abort. It needs sixteen separate attempts on one descriptor, and each attempt must be restarted from the waiting state before it can collide inside the first 128 nibble slots. The stimulus reaches it with a scenario task that replays a start tick and a collision at a chosen slot for each attempt. The task is run directly with 15 and with 16 collisions, and random frames now and then ask for the full sixteen. The deferral limit at 6070 and 6071 busy ticks and the late-collision edge at slots 127 and 128 are also reached only by long directed runs.

// File: rtl/txd_pkg.sv
// Package: shared state encoding, status record and writeback packing for
// the transmit descriptor sequencer. Assumes the fixed 32-bit descriptor
// layout (owner 31, status 30:18, widget 17:16, length 15:0).
package txd_pkg;

    localparam int LEN_W   = 16;
    localparam int WID_W   = 2;
    localparam int OWN_BIT = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XMIT = 2'd2
    } txd_state_e;

    typedef struct packed {
        logic paused;
        logic halted;
        logic sqe;
        logic deferred;
        logic coll;
        logic par;
        logic late;
        logic nocarr;
        logic deferr;
        logic unf;
        logic excoll;
    } txd_stat_t;

    // Builds the returned word: owner cleared, reserved 0, complete set.
    function automatic logic [31:0] pack_wb(input txd_stat_t s,
                                            input logic [WID_W-1:0] wid,
                                            input logic [LEN_W-1:0] len);
        return {1'b0, 1'b0, s.paused, s.halted, s.sqe, s.deferred, s.coll,
                1'b1, s.par, s.late, s.nocarr, s.deferr, s.unf, s.excoll,
                wid, len};
    endfunction

endpackage

// File: rtl/txd_defer_timer.sv
// Deferral timer: counts busy nibble ticks within one waiting period and
// flags the tick that reaches the abort limit. Assumes the controller
// clears it whenever it is not waiting.
module txd_defer_timer #(
    parameter int LIMIT = 6071
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_C = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Flags the busy tick that would be the LIMIT-th of this wait.
    assign expire = count_en && (cnt_q == LAST_C);

    // Advances on each busy tick, restarts when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (count_en && !expire) cnt_q <= cnt_q + 1'b1;
    end

    // R6: the count never passes the abort point inside one wait.
    p_defer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> (cnt_q <= LAST_C));
endmodule

// File: rtl/txd_coll_counter.sv
// Collision retry counter: counts early collisions of one descriptor and
// marks when the next collision is the final one allowed. Assumes it is
// cleared on descriptor acceptance.
module txd_coll_counter #(
    parameter int MAX_COLL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_COLL + 1);
    localparam logic [CW-1:0] LAST_C = CW'(MAX_COLL - 1);

    logic [CW-1:0] cnt_q;

    // The collision arriving now would be the MAX_COLL-th.
    assign last = (cnt_q == LAST_C);

    // Counts retried collisions of the current descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    // R8: a retry is never requested on the final allowed collision.
    p_no_retry_past_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last);
endmodule

// File: rtl/txd_xmit_meter.sv
// Transmit meter: counts sent nibble slots of one attempt, says when the
// current tick is the last slot of the frame and when the late-collision
// window has opened. Assumes it is cleared outside transmission.
module txd_xmit_meter #(
    parameter int LEN_W    = 16,
    parameter int LATE_NIB = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             last_nib,
    output logic             late_zone
);
    localparam int CW = LEN_W + 1;
    localparam logic [CW-1:0] LATE_C = CW'(LATE_NIB);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;

    // Frame size in nibble slots; an empty frame takes one slot.
    assign target    = (len == '0) ? CW'(1) : {len, 1'b0};
    assign last_nib  = (cnt_q + 1'b1) >= target;
    assign late_zone = cnt_q >= LATE_C;

    // Counts slots sent in the current attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // R3: the controller never lets a tick run past the frame's last slot.
    p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q < target));
endmodule

// File: rtl/txd_status_wb.sv
// Transmit descriptor sequencer: accepts a DMA-owned descriptor, waits for
// the medium under halt/pause/enable gating, transmits with collision
// retry, and writes back the descriptor with status and CPU ownership.
// Assumes all event inputs are meaningful only on nib_tick cycles.
module txd_status_wb
    import txd_pkg::*;
#(
    parameter int DEFER_LIMIT = 6071,
    parameter int MAX_COLL    = 16,
    parameter int LATE_NIB    = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        desc_valid,
    input  logic [31:0] desc_word,
    input  logic        nib_tick,
    input  logic        crs,
    input  logic        col,
    input  logic        fifo_unf,
    input  logic        fifo_par,
    input  logic        sqe_err,
    input  logic        pause_req,
    input  logic        halt_imm,
    input  logic        tx_en,
    output logic        idle,
    output logic        wb_valid,
    output logic [31:0] wb_word
);
    txd_state_e       st_q, st_nx;
    txd_stat_t        stat_q, stat_nx;
    logic [LEN_W-1:0] len_q;
    logic [WID_W-1:0] wid_q;
    logic             first_q, carrier_q;
    logic             wb_valid_q;
    logic [31:0]      wb_word_q;
    logic             unused_status_in;

    logic accept, tick_wait, tick_x, blocked, start, busy;
    logic defer_exp, coll_last, last_nib, late_zone;
    logic par_hit, unf_hit, col_hit, late_hit, exc_hit, retry, ok_hit;
    logic terminal;

    assign unused_status_in = ^desc_word[30:18];

    // Event decode for the waiting and transmitting phases.
    always_comb begin
        accept    = (st_q == ST_IDLE) && desc_valid && desc_word[OWN_BIT];
        tick_wait = (st_q == ST_WAIT) && nib_tick;
        tick_x    = (st_q == ST_XMIT) && nib_tick;
        blocked   = halt_imm || !tx_en;
        start     = tick_wait && !blocked && !pause_req && !crs;
        busy      = tick_wait && !blocked && !pause_req && crs;
        par_hit   = tick_x && fifo_par;
        unf_hit   = tick_x && !fifo_par && fifo_unf;
        col_hit   = tick_x && !fifo_par && !fifo_unf && col;
        late_hit  = col_hit && late_zone;
        exc_hit   = col_hit && !late_zone && coll_last;
        retry     = col_hit && !late_zone && !coll_last;
        ok_hit    = tick_x && !fifo_par && !fifo_unf && !col && last_nib;
        terminal  = (busy && defer_exp) || par_hit || unf_hit || late_hit
                    || exc_hit || ok_hit;
    end

    txd_defer_timer #(.LIMIT(DEFER_LIMIT)) defer_i (
        .clk(clk), .rst_n(rst_n), .clear(st_q != ST_WAIT),
        .count_en(busy), .expire(defer_exp));

    txd_coll_counter #(.MAX_COLL(MAX_COLL)) coll_i (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .inc(retry), .last(coll_last));

    txd_xmit_meter #(.LEN_W(LEN_W), .LATE_NIB(LATE_NIB)) meter_i (
        .clk(clk), .rst_n(rst_n), .clear(st_q != ST_XMIT),
        .tick(tick_x), .len(len_q), .last_nib(last_nib),
        .late_zone(late_zone));

    // Next state of the sequencer.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_nx = ST_WAIT;
            ST_WAIT: if (terminal) st_nx = ST_IDLE;
                     else if (start) st_nx = ST_XMIT;
            ST_XMIT: if (terminal) st_nx = ST_IDLE;
                     else if (retry) st_nx = ST_WAIT;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Status accumulation for the current descriptor.
    always_comb begin
        stat_nx = accept ? '0 : stat_q;
        if (tick_wait) begin
            if (blocked) stat_nx.halted = 1'b1;
            else if (pause_req) stat_nx.paused = 1'b1;
            else if (crs) begin
                if (first_q) stat_nx.deferred = 1'b1;
                if (defer_exp) stat_nx.deferr = 1'b1;
            end
        end
        if (tick_x && sqe_err) stat_nx.sqe = 1'b1;
        if (par_hit) stat_nx.par = 1'b1;
        if (unf_hit) stat_nx.unf = 1'b1;
        if (col_hit) stat_nx.coll = 1'b1;
        if (late_hit) stat_nx.late = 1'b1;
        if (exc_hit) stat_nx.excoll = 1'b1;
        if (ok_hit && !(carrier_q || crs)) stat_nx.nocarr = 1'b1;
    end

    // State, descriptor fields, attempt flags and writeback registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            stat_q     <= '0;
            len_q      <= '0;
            wid_q      <= '0;
            first_q    <= 1'b0;
            carrier_q  <= 1'b0;
            wb_valid_q <= 1'b0;
            wb_word_q  <= '0;
        end else begin
            st_q       <= st_nx;
            stat_q     <= stat_nx;
            wb_valid_q <= terminal;
            if (accept) begin
                len_q   <= desc_word[LEN_W-1:0];
                wid_q   <= desc_word[LEN_W+WID_W-1:LEN_W];
                first_q <= 1'b1;
            end else if (start) begin
                first_q <= 1'b0;
            end
            if (start) carrier_q <= 1'b0;
            else if (tick_x && crs) carrier_q <= 1'b1;
            if (terminal) wb_word_q <= pack_wb(stat_nx, wid_q, len_q);
        end
    end

    assign idle     = (st_q == ST_IDLE);
    assign wb_valid = wb_valid_q;
    assign wb_word  = wb_word_q;

    // R2: the writeback strobe lasts a single cycle.
    p_wb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    // R1: a CPU-owned descriptor leaves the block idle with no writeback.
    p_ignore_cpu_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && desc_valid && !desc_word[OWN_BIT]) |=> (idle && !wb_valid));

    // R11: a halted or disabled waiting tick never starts transmission.
    p_halt_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_WAIT) && nib_tick && (halt_imm || !tx_en)) |=> (st_q == ST_WAIT));

    // R2: writeback always returns ownership to the CPU.
    p_wb_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> (!wb_word[31] && wb_word[24] && idle));
endmodule

// File: tb/txd_status_wb_tb.sv
// Bench: directed corner cases plus seeded random frames, each checked
// against a writeback word computed from the requirements.
module txd_status_wb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic [31:0] desc_word = '0;
    logic        nib_tick = 1'b0, crs = 1'b0, col = 1'b0, fifo_unf = 1'b0;
    logic        fifo_par = 1'b0, sqe_err = 1'b0, pause_req = 1'b0;
    logic        halt_imm = 1'b0, tx_en = 1'b1;
    logic        idle, wb_valid;
    logic [31:0] wb_word;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, wb_cnt = 0, wb_cyc = 0, tick_cyc = 0;
    logic [31:0] wb_got = '0;

    always #4 clk = ~clk;

    txd_status_wb dut_i (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_word(desc_word),
        .nib_tick(nib_tick), .crs(crs), .col(col), .fifo_unf(fifo_unf),
        .fifo_par(fifo_par), .sqe_err(sqe_err), .pause_req(pause_req),
        .halt_imm(halt_imm), .tx_en(tx_en), .idle(idle), .wb_valid(wb_valid),
        .wb_word(wb_word));

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (wb_valid) begin
        wb_cnt <= wb_cnt + 1;
        wb_got <= wb_word;
        wb_cyc <= cyc;
    end

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish (got hang, expected end)");
        summary_and_end();
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_tick(input bit c_crs, c_col, c_unf, c_par, c_pause,
                           c_halt, c_en, c_sqe);
        @(negedge clk);
        {crs, col, fifo_unf, fifo_par, pause_req, halt_imm, tx_en, sqe_err} =
            {c_crs, c_col, c_unf, c_par, c_pause, c_halt, c_en, c_sqe};
        nib_tick = 1'b1;
        @(negedge clk);
        tick_cyc = cyc;
        {crs, col, fifo_unf, fifo_par, pause_req, halt_imm, sqe_err} = '0;
        tx_en = 1'b1;
        nib_tick = 1'b0;
    endtask

    task automatic send_desc(input logic [31:0] w);
        @(negedge clk);
        desc_valid = 1'b1;
        desc_word  = w;
        @(negedge clk);
        desc_valid = 1'b0;
        desc_word  = '0;
    endtask

    // Expected writeback from the scenario (outcome: 0 ok, 1 unf, 2 par, 3 late, 4 unf+par).
    function automatic logic [31:0] exp_word(input logic [15:0] len, input logic [1:0] wid,
            input int n_halt, n_pause, n_busy, n_col, outcome, input bit carrier, sqe);
        bit dab = n_busy >= 6071;
        bit exc = !dab && n_col >= 16;
        bit fin = !dab && !exc;
        bit coll = !dab && (n_col > 0 || (fin && outcome == 3));
        return {1'b0, 1'b0, 1'(n_pause > 0), 1'(n_halt > 0), 1'(!dab && sqe),
                1'(n_busy > 0), coll, 1'b1, 1'(fin && (outcome == 2 || outcome == 4)),
                1'(fin && outcome == 3), 1'(fin && outcome == 0 && !carrier), dab,
                1'(fin && outcome == 1), exc, wid, len};
    endfunction

    task automatic run_frame(input logic [15:0] len, input logic [1:0] wid,
            input int n_halt, n_pause, n_busy, n_col, input int fix_c,
            input int outcome, input int k, input bit carrier, sqe, input string req);
        int total = (len == 0) ? 1 : 2 * len;
        int cmax  = (total < 128) ? total : 128;
        wb_cnt = 0;
        send_desc({1'b1, 13'h1fff, wid, len});
        chk({31'd0, idle}, 32'd0, {req, " R1 accept drops idle"});
        for (int i = 0; i < n_halt; i++) do_tick(0, 0, 0, 0, 0, i % 2 == 0, i % 2 == 0, 0);
        for (int i = 0; i < n_pause; i++) do_tick(0, 0, 0, 0, 1, 0, 1, 0);
        for (int i = 0; i < n_busy && i < 6071; i++) do_tick(1, 0, 0, 0, 0, 0, 1, 0);
        if (n_busy < 6071) begin
            for (int a = 0; a < n_col && a < 16; a++) begin
                int c = (fix_c >= 0) ? fix_c : int'($urandom_range(cmax - 1, 0));
                do_tick(0, 0, 0, 0, 0, 0, 1, 0);
                for (int t = 0; t <= c; t++)
                    do_tick(carrier, t == c, 0, 0, 0, 0, 1, sqe && a == 0 && t == 0);
            end
            if (n_col < 16) begin
                do_tick(0, 0, 0, 0, 0, 0, 1, 0);
                for (int t = 0; t < total; t++) begin
                    bit hit = (outcome != 0) && (t == k);
                    do_tick(carrier, hit && outcome == 3, hit && (outcome == 1 || outcome == 4),
                            hit && (outcome == 2 || outcome == 4), 0, 0, 1,
                            sqe && n_col == 0 && t == 0);
                    if (hit) break;
                end
            end
        end
        repeat (3) @(negedge clk);
        chk(wb_cnt, 1, {req, " R2 one writeback"});
        chk(wb_got, exp_word(len, wid, n_halt, n_pause, n_busy, n_col, outcome, carrier, sqe),
            {req, " R2 word"});
        chk(wb_cyc, tick_cyc, {req, " R2 strobe timing"});
        chk({31'd0, idle}, 32'd1, {req, " idle after"});
    endtask

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        chk({30'd0, idle, wb_valid}, 32'd2, "R2 reset state");
        rst_n = 1'b1;
        // R1: CPU-owned descriptor is ignored
        wb_cnt = 0;
        send_desc(32'h0003_0010);
        for (int i = 0; i < 6; i++) do_tick(0, 0, 0, 0, 0, 0, 1, 0);
        chk({31'd0, idle}, 32'd1, "R1 idle stays high");
        chk(wb_cnt, 0, "R1 no writeback");
        run_frame(16'd5, 2'd1, 0, 0, 0, 0, -1, 0, 0, 1, 0, "R3 plain");
        run_frame(16'd0, 2'd2, 0, 0, 0, 0, -1, 0, 0, 1, 0, "R3 zero length");
        run_frame(16'd3, 2'd0, 0, 0, 0, 0, -1, 0, 0, 0, 0, "R4 no carrier");
        run_frame(16'd4, 2'd3, 0, 0, 10, 0, -1, 0, 0, 1, 0, "R5 deferred");
        run_frame(16'd2, 2'd1, 0, 0, 6071, 0, -1, 0, 0, 1, 0, "R6 defer abort");
        run_frame(16'd2, 2'd1, 0, 0, 6070, 0, -1, 0, 0, 1, 0, "R6 just below limit");
        run_frame(16'd6, 2'd0, 0, 0, 0, 2, -1, 0, 0, 1, 0, "R7 retry");
        run_frame(16'd3, 2'd2, 0, 0, 0, 15, -1, 0, 0, 1, 0, "R8 fifteen collisions");
        run_frame(16'd3, 2'd2, 0, 0, 0, 16, -1, 0, 0, 1, 0, "R8 excessive");
        run_frame(16'd100, 2'd1, 0, 0, 0, 0, -1, 3, 128, 1, 0, "R9 late");
        run_frame(16'd100, 2'd1, 0, 0, 0, 1, 127, 0, 0, 1, 0, "R9 slot 127 retries");
        run_frame(16'd8, 2'd3, 0, 0, 0, 0, -1, 1, 3, 1, 0, "R10 underflow");
        run_frame(16'd8, 2'd3, 0, 0, 0, 0, -1, 2, 3, 1, 0, "R10 parity");
        run_frame(16'd8, 2'd3, 0, 0, 0, 0, -1, 4, 3, 1, 0, "R10 parity wins");
        run_frame(16'd3, 2'd0, 4, 0, 0, 0, -1, 0, 0, 1, 0, "R11 halted");
        run_frame(16'd3, 2'd0, 0, 3, 0, 0, -1, 0, 0, 1, 0, "R12 paused");
        run_frame(16'd3, 2'd0, 0, 0, 0, 0, -1, 0, 0, 1, 1, "R13 sqe");
        run_frame(16'd3, 2'd1, 2, 2, 3, 1, -1, 1, 1, 0, 1, "R14 dirty frame");
        run_frame(16'd3, 2'd1, 0, 0, 0, 0, -1, 0, 0, 1, 0, "R14 clean after dirty");
        for (int f = 0; f < 40; f++) begin
            logic [15:0] len = 16'($urandom_range(90, 0));
            int oc = int'($urandom_range(4, 0));
            int total, k, ncol;
            if (oc == 3) len = 16'($urandom_range(200, 70));
            total = (len == 0) ? 1 : 2 * int'(len);
            if (oc == 3 && total <= 128) oc = 0;
            k = (oc == 3) ? int'($urandom_range(total - 1, 128))
                          : int'($urandom_range(total - 1, 0));
            ncol = ($urandom_range(9, 0) == 0) ? 16 : int'($urandom_range(4, 0));
            run_frame(len, 2'($urandom), int'($urandom_range(3, 0)),
                      int'($urandom_range(3, 0)), int'($urandom_range(20, 0)), ncol, -1,
                      oc, k, 1'($urandom), 1'($urandom), "random R3 R7 R14");
        end
        summary_and_end();
    end
endmodule